// File: doc/BRIEF.md
# CSR Read-Modify-Write Execution Unit

This unit executes the six control-and-status-register access instructions against a small local register bank. Each cycle in which `i_valid` is high it takes one 32-bit instruction word and the value of its first source register. It decodes the register specifier and the operation. It returns the register's previous value for the destination register, and it applies a whole-value write, a set-bits update or a clear-bits update. Each register has its own mask of writable bits.

Reads and writes are enabled separately. A plain or immediate write whose destination index is zero does not read the register. A set or clear whose source index is zero, or whose immediate is zero, does not write. Two strobes report to the surrounding logic that a real read or a real write has taken place. An access that would modify a read-only register, or that names a register the bank does not hold, raises a one-cycle illegal-instruction flag and changes nothing. The bank also holds a retired-instruction counter. Every legal access advances it by one, except an access that writes the counter explicitly: that write takes the place of the increment.

Register map, with the default parameters:
- Four scratch registers sit at `SCRATCH_BASE + i`, which is 0x340 to 0x343. In register i the top `MASK_STEP*i` bits are fixed: reg0 mask `FFFFFFFF`, reg1 `0FFFFFFF`, reg2 `00FFFFFF`, reg3 `000FFFFF`.
- The retired-instruction counter is writable at 0xB02 and has a read-only alias at 0xC02.
- A read-only constant register at 0xF11 returns `ID_VALUE`, which defaults to `0x00001234`.

Top module: `csr_rmw_unit`

## Requirements
- R1: Instruction fields are taken as follows: specifier from bits 31:20, source index or uimm from 19:15, operation code from 14:12, destination index from 11:7, major opcode from 6:0. A legal access needs major opcode 7'b1110011 and an operation code of 001 (write), 010 (set), 011 (clear), 101 (write-imm), 110 (set-imm) or 111 (clear-imm). Any other opcode or operation code raises `o_illegal` and has no other effect. `o_addr` returns the specifier of every accepted access.
- R2: Write and write-imm always write. When the destination index is 0 they do not read: `o_rd_strobe` stays 0 and `o_rd_data` is 0. Whenever `o_rd_strobe` is 0, `o_rd_data` is 0.
- R3: Set, clear, set-imm and clear-imm always read and pulse `o_rd_strobe`, whatever the destination and source indexes are.
- R4: Set and clear with source index 0, and set-imm and clear-imm with uimm 0, do not write and do not pulse `o_wr_strobe`. On a read-only register they raise no illegal flag.
- R5: Set or clear with a nonzero source index whose value is zero still counts as a write. The unchanged value is written back and `o_wr_strobe` pulses.
- R6: A write replaces the writable bits with the operand. A set ORs the operand into them. A clear removes the operand's 1 bits from them. Bits outside the register's writable mask keep their value.
- R7: Immediate forms zero-extend the 5-bit uimm to XLEN and ignore `i_rs1_val`. `o_rd_data` carries the old value zero-extended to XLEN.
- R8: A register whose specifier has bits 11:10 equal to 2'b11 is read-only. An access that would write such a register, or any access to an unimplemented specifier, raises `o_illegal` with both strobes low and `o_rd_data` 0, and leaves every register unchanged.
- R9: A read of the counter returns its value before the current access. Each legal access adds one. Illegal accesses and idle cycles add nothing. An explicit write to the counter sets it to the written value in place of the increment.
- R10: Results are registered. They appear in the cycle after the accepted edge, together with `o_done`, for exactly one cycle. In a cycle that follows `i_valid` low, `o_done`, both strobes and `o_illegal` are 0.
- R11: Synchronous reset clears all outputs, the scratch registers and the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| i_clk | input | 1 | Clock |
| i_rst | input | 1 | Synchronous active-high reset |
| i_valid | input | 1 | An instruction is presented this cycle |
| i_instr | input | 32 | Instruction word |
| i_rs1_val | input | XLEN | Value of the source register |
| o_done | output | 1 | Result of the previous cycle's access is valid |
| o_addr | output | 12 | Specifier of the completed access |
| o_rd_data | output | XLEN | Old register value for the destination |
| o_rd_strobe | output | 1 | A read took place |
| o_wr_strobe | output | 1 | A write took place |
| o_illegal | output | 1 | The access was illegal |

## Verification
Every result comes from a register that is loaded on the edge that accepts the access, so all outputs are due one cycle after it. The register state that a later access reads is also updated on that same edge. The bench drives each access on a falling edge and samples shortly after the next rising edge, one sample per access. A row-by-row table covers the decode and update rules, and the expected values follow from the state left by the rows before it. Directed sequences then cover reset, idle cycles and the counter's ordering, including a counter read that follows an idle cycle and one that follows an illegal access.

// File: rtl/csr_rmw_pkg.sv
package csr_rmw_pkg;

    localparam logic [6:0] SYS_OPCODE = 7'b1110011;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_WRITE = 2'b01,
        OP_SET   = 2'b10,
        OP_CLEAR = 2'b11
    } csr_op_e;

    typedef struct packed {
        logic        legal;
        csr_op_e     op;
        logic        use_imm;
        logic [11:0] addr;
        logic [4:0]  src;
        logic [4:0]  rd;
        logic        do_read;
        logic        do_write;
    } csr_dec_t;

    function automatic logic spec_read_only(input logic [11:0] spec);
        return spec[11:10] == 2'b11;
    endfunction

    function automatic logic f3_legal(input logic [2:0] f3);
        return f3[1:0] != 2'b00;
    endfunction

endpackage

// File: rtl/csr_rmw_decode.sv
module csr_rmw_decode
    import csr_rmw_pkg::*;
(
    input  logic [31:0] i_instr,
    output csr_dec_t    o_dec
);

    logic [2:0] f3;

    always_comb begin
        f3             = i_instr[14:12];
        o_dec.addr     = i_instr[31:20];
        o_dec.src      = i_instr[19:15];
        o_dec.rd       = i_instr[11:7];
        o_dec.use_imm  = f3[2];
        o_dec.op       = csr_op_e'(f3[1:0]);
        o_dec.legal    = (i_instr[6:0] == SYS_OPCODE) && f3_legal(f3);
        if (o_dec.op == OP_WRITE) begin
            o_dec.do_read  = (o_dec.rd != 5'd0);
            o_dec.do_write = 1'b1;
        end else begin
            o_dec.do_read  = 1'b1;
            o_dec.do_write = (o_dec.src != 5'd0);
        end
    end

endmodule

// File: rtl/csr_rmw_bank.sv
module csr_rmw_bank
    import csr_rmw_pkg::*;
#(
    parameter int          XLEN         = 32,
    parameter int          N_SCRATCH    = 4,
    parameter int          MASK_STEP    = 4,
    parameter logic [11:0] SCRATCH_BASE = 12'h340,
    parameter logic [11:0] CNT_ADDR     = 12'hB02,
    parameter logic [11:0] CNT_ALIAS    = 12'hC02,
    parameter logic [11:0] ID_ADDR      = 12'hF11,
    parameter logic [XLEN-1:0] ID_VALUE = XLEN'(32'h0000_1234)
) (
    input  logic            i_clk,
    input  logic            i_rst,
    input  logic [11:0]     i_addr,
    input  logic            i_commit,
    input  logic            i_wr,
    input  csr_op_e         i_op,
    input  logic [XLEN-1:0] i_operand,
    output logic            o_hit,
    output logic            o_ro,
    output logic [XLEN-1:0] o_rdata
);

    localparam logic [XLEN-1:0] ALL_ONES = {XLEN{1'b1}};

    function automatic logic [XLEN-1:0] merge(
        input logic [XLEN-1:0] old,
        input csr_op_e         op,
        input logic [XLEN-1:0] val,
        input logic [XLEN-1:0] mask
    );
        logic [XLEN-1:0] nv;
        case (op)
            OP_WRITE: nv = val;
            OP_SET:   nv = old | val;
            OP_CLEAR: nv = old & ~val;
            default:  nv = old;
        endcase
        return (old & ~mask) | (nv & mask);
    endfunction

    logic [XLEN-1:0] scratch [N_SCRATCH];
    logic [XLEN-1:0] scratch_rd [N_SCRATCH];
    logic [N_SCRATCH-1:0] sel;
    logic [XLEN-1:0] retired;
    logic cnt_sel, alias_sel, id_sel;

    for (genvar g = 0; g < N_SCRATCH; g++) begin : g_scr
        localparam logic [11:0]     REG_ADDR = SCRATCH_BASE + 12'(g);
        localparam logic [XLEN-1:0] REG_MASK = ALL_ONES >> (MASK_STEP * g);

        assign sel[g]        = (i_addr == REG_ADDR);
        assign scratch_rd[g] = sel[g] ? scratch[g] : '0;

        always_ff @(posedge i_clk) begin
            if (i_rst)
                scratch[g] <= '0;
            else if (i_commit && i_wr && sel[g])
                scratch[g] <= merge(scratch[g], i_op, i_operand, REG_MASK);
        end

        AST_SCRATCH_HOLD: assert property (@(posedge i_clk) disable iff (i_rst)
            !(i_commit && i_wr && sel[g]) |=> $stable(scratch[g])); // R8
    end

    assign cnt_sel   = (i_addr == CNT_ADDR);
    assign alias_sel = (i_addr == CNT_ALIAS);
    assign id_sel    = (i_addr == ID_ADDR);

    always_ff @(posedge i_clk) begin
        if (i_rst)
            retired <= '0;
        else if (i_commit) begin
            if (i_wr && cnt_sel)
                retired <= merge(retired, i_op, i_operand, ALL_ONES);
            else
                retired <= retired + 1'b1;
        end
    end

    always_comb begin
        o_rdata = '0;
        for (int k = 0; k < N_SCRATCH; k++)
            o_rdata = o_rdata | scratch_rd[k];
        if (cnt_sel || alias_sel)
            o_rdata = retired;
        if (id_sel)
            o_rdata = ID_VALUE;
    end

    assign o_hit = (|sel) || cnt_sel || alias_sel || id_sel;
    assign o_ro  = spec_read_only(i_addr);

    AST_CNT_IDLE: assert property (@(posedge i_clk) disable iff (i_rst)
        !i_commit |=> $stable(retired)); // R9
    AST_CNT_STEP: assert property (@(posedge i_clk) disable iff (i_rst)
        (i_commit && !(i_wr && cnt_sel)) |=> retired == $past(retired) + 1'b1); // R9

endmodule

// File: rtl/csr_rmw_unit.sv
module csr_rmw_unit
    import csr_rmw_pkg::*;
#(
    parameter int          XLEN         = 32,
    parameter int          N_SCRATCH    = 4,
    parameter int          MASK_STEP    = 4,
    parameter logic [11:0] SCRATCH_BASE = 12'h340,
    parameter logic [11:0] CNT_ADDR     = 12'hB02,
    parameter logic [11:0] CNT_ALIAS    = 12'hC02,
    parameter logic [11:0] ID_ADDR      = 12'hF11,
    parameter logic [XLEN-1:0] ID_VALUE = XLEN'(32'h0000_1234)
) (
    input  logic            i_clk,
    input  logic            i_rst,
    input  logic            i_valid,
    input  logic [31:0]     i_instr,
    input  logic [XLEN-1:0] i_rs1_val,
    output logic            o_done,
    output logic [11:0]     o_addr,
    output logic [XLEN-1:0] o_rd_data,
    output logic            o_rd_strobe,
    output logic            o_wr_strobe,
    output logic            o_illegal
);

    localparam int IMM_W = 5;

    csr_dec_t        dec;
    logic [XLEN-1:0] operand;
    logic [XLEN-1:0] rdata;
    logic            hit, ro, bad, commit;

    csr_rmw_decode u_dec (
        .i_instr (i_instr),
        .o_dec   (dec)
    );

    assign operand = dec.use_imm ? {{(XLEN-IMM_W){1'b0}}, dec.src} : i_rs1_val;
    assign bad     = !dec.legal || !hit || (dec.do_write && ro);
    assign commit  = i_valid && !bad;

    csr_rmw_bank #(
        .XLEN         (XLEN),
        .N_SCRATCH    (N_SCRATCH),
        .MASK_STEP    (MASK_STEP),
        .SCRATCH_BASE (SCRATCH_BASE),
        .CNT_ADDR     (CNT_ADDR),
        .CNT_ALIAS    (CNT_ALIAS),
        .ID_ADDR      (ID_ADDR),
        .ID_VALUE     (ID_VALUE)
    ) u_bank (
        .i_clk     (i_clk),
        .i_rst     (i_rst),
        .i_addr    (dec.addr),
        .i_commit  (commit),
        .i_wr      (dec.do_write),
        .i_op      (dec.op),
        .i_operand (operand),
        .o_hit     (hit),
        .o_ro      (ro),
        .o_rdata   (rdata)
    );

    always_ff @(posedge i_clk) begin
        if (i_rst) begin
            o_done      <= 1'b0;
            o_addr      <= '0;
            o_rd_data   <= '0;
            o_rd_strobe <= 1'b0;
            o_wr_strobe <= 1'b0;
            o_illegal   <= 1'b0;
        end else begin
            o_done      <= i_valid;
            o_addr      <= i_valid ? dec.addr : o_addr;
            o_rd_data   <= (commit && dec.do_read) ? rdata : '0;
            o_rd_strobe <= commit && dec.do_read;
            o_wr_strobe <= commit && dec.do_write;
            o_illegal   <= i_valid && bad;
        end
    end

    AST_ILLEGAL_QUIET: assert property (@(posedge i_clk) disable iff (i_rst)
        o_illegal |-> !o_rd_strobe && !o_wr_strobe && o_rd_data == '0); // R8
    AST_RO_NEVER_WRITTEN: assert property (@(posedge i_clk) disable iff (i_rst)
        o_wr_strobe |-> !spec_read_only(o_addr)); // R8
    AST_FLAGS_NEED_DONE: assert property (@(posedge i_clk) disable iff (i_rst)
        (o_rd_strobe || o_wr_strobe || o_illegal) |-> o_done); // R10
    AST_IDLE_QUIET: assert property (@(posedge i_clk) disable iff (i_rst)
        !i_valid |=> !o_done && !o_illegal); // R10
    AST_NO_READ_ZERO: assert property (@(posedge i_clk) disable iff (i_rst)
        !o_rd_strobe |-> o_rd_data == '0); // R2
    AST_WRITE_ALWAYS: assert property (@(posedge i_clk) disable iff (i_rst)
        (i_valid && dec.legal && dec.op == OP_WRITE) |=> (o_wr_strobe || o_illegal)); // R2
    AST_SETCLR_READS: assert property (@(posedge i_clk) disable iff (i_rst)
        (i_valid && dec.legal && dec.op != OP_WRITE) |=> (o_rd_strobe || o_illegal)); // R3
    AST_ZERO_SRC_NO_WRITE: assert property (@(posedge i_clk) disable iff (i_rst)
        (i_valid && dec.op != OP_WRITE && dec.src == 5'd0) |=> !o_wr_strobe); // R4

endmodule

// File: tb/csr_rmw_unit_tb.sv
`timescale 1ns/1ps
module csr_rmw_unit_tb;

    localparam int XLEN = 32;
    localparam logic [31:0] ID_V = 32'h0000_1234;

    typedef struct packed {
        logic [31:0] instr;
        logic [31:0] rs1;
        logic [31:0] rd;
        logic        rs;
        logic        ws;
        logic        ill;
    } vec_t;

    function automatic logic [31:0] enc(input logic [11:0] spec, input logic [4:0] s,
                                        input logic [2:0] f3, input logic [4:0] d);
        return {spec, s, f3, d, 7'b1110011};
    endfunction

    localparam int NV = 22;
    localparam vec_t TBL [NV] = '{
        '{enc(12'h340, 5'd2,  3'd1, 5'd1), 32'hA5A5_0000, 32'h0,         1'b1, 1'b1, 1'b0}, // 0 R6
        '{enc(12'h340, 5'd3,  3'd2, 5'd1), 32'h0000_00FF, 32'hA5A5_0000, 1'b1, 1'b1, 1'b0}, // 1 R6
        '{enc(12'h340, 5'd3,  3'd3, 5'd0), 32'hA000_0000, 32'hA5A5_00FF, 1'b1, 1'b1, 1'b0}, // 2 R3
        '{enc(12'h340, 5'd0,  3'd2, 5'd5), 32'hFFFF_FFFF, 32'h05A5_00FF, 1'b1, 1'b0, 1'b0}, // 3 R4
        '{enc(12'h341, 5'd1,  3'd1, 5'd0), 32'hFFFF_FFFF, 32'h0,         1'b0, 1'b1, 1'b0}, // 4 R2
        '{enc(12'h341, 5'd4,  3'd2, 5'd2), 32'h0,         32'h0FFF_FFFF, 1'b1, 1'b1, 1'b0}, // 5 R5
        '{enc(12'h341, 5'h1F, 3'd7, 5'd2), 32'h0,         32'h0FFF_FFFF, 1'b1, 1'b1, 1'b0}, // 6 R7
        '{enc(12'h341, 5'd0,  3'd6, 5'd2), 32'hDEAD_BEEF, 32'h0FFF_FFE0, 1'b1, 1'b0, 1'b0}, // 7 R4
        '{enc(12'h342, 5'h15, 3'd5, 5'd3), 32'hFFFF_FFFF, 32'h0,         1'b1, 1'b1, 1'b0}, // 8 R7
        '{enc(12'h342, 5'd6,  3'd2, 5'd3), 32'hFFFF_FFFF, 32'h0000_0015, 1'b1, 1'b1, 1'b0}, // 9 R6
        '{enc(12'h342, 5'd0,  3'd2, 5'd3), 32'h0,         32'h00FF_FFFF, 1'b1, 1'b0, 1'b0}, // 10 R6
        '{enc(12'h343, 5'd7,  3'd1, 5'd1), 32'hFFFF_FFFF, 32'h0,         1'b1, 1'b1, 1'b0}, // 11 R6
        '{enc(12'h343, 5'd7,  3'd3, 5'd1), 32'h0000_F0F0, 32'h000F_FFFF, 1'b1, 1'b1, 1'b0}, // 12 R6
        '{enc(12'hF11, 5'd0,  3'd2, 5'd1), 32'h0,         ID_V,          1'b1, 1'b0, 1'b0}, // 13 R4
        '{enc(12'hF11, 5'd2,  3'd2, 5'd1), 32'h1,         32'h0,         1'b0, 1'b0, 1'b1}, // 14 R8
        '{enc(12'h343, 5'd7,  3'd4, 5'd1), 32'hFFFF_FFFF, 32'h0,         1'b0, 1'b0, 1'b1}, // 15 R1
        '{enc(12'h7FF, 5'd7,  3'd1, 5'd1), 32'hFFFF_FFFF, 32'h0,         1'b0, 1'b0, 1'b1}, // 16 R8
        '{enc(12'h343, 5'd7,  3'd1, 5'd1) ^ 32'h40, 32'hFFFF_FFFF, 32'h0, 1'b0, 1'b0, 1'b1}, // 17 R1
        '{enc(12'hF11, 5'd0,  3'd5, 5'd0), 32'h0,         32'h0,         1'b0, 1'b0, 1'b1}, // 18 R8
        '{enc(12'h343, 5'd0,  3'd2, 5'd1), 32'h0,         32'h000F_0F0F, 1'b1, 1'b0, 1'b0}, // 19 R8
        '{enc(12'h340, 5'h1F, 3'd5, 5'd1), 32'hFFFF_FFFF, 32'h05A5_00FF, 1'b1, 1'b1, 1'b0}, // 20 R7
        '{enc(12'h340, 5'd0,  3'd2, 5'd1), 32'h0,         32'h0000_001F, 1'b1, 1'b0, 1'b0}  // 21 R7
    };

    function automatic string row_req(input int i);
        case (i)
            0, 1, 9, 10, 11, 12: return "R6";
            2:                   return "R3";
            3, 7, 13:            return "R4";
            4:                   return "R2";
            5:                   return "R5";
            6, 8, 20, 21:        return "R7";
            15, 17:              return "R1";
            default:             return "R8";
        endcase
    endfunction

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            valid = 1'b0;
    logic [31:0]     instr = '0;
    logic [XLEN-1:0] rs1 = '0;
    logic            done, rds, wrs, ill;
    logic [11:0]     addr;
    logic [XLEN-1:0] rdd;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    csr_rmw_unit u_dut (
        .i_clk       (clk),
        .i_rst       (rst),
        .i_valid     (valid),
        .i_instr     (instr),
        .i_rs1_val   (rs1),
        .o_done      (done),
        .o_addr      (addr),
        .o_rd_data   (rdd),
        .o_rd_strobe (rds),
        .o_wr_strobe (wrs),
        .o_illegal   (ill)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] ins, input logic [31:0] v);
        @(negedge clk);
        valid = 1'b1;
        instr = ins;
        rs1   = v;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        valid = 1'b0;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        valid = 1'b0;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic expect_out(input string req, input logic [31:0] d,
                              input logic r, input logic w, input logic i);
        chk(req, "done",      32'(done), 32'd1);
        chk(req, "rd_data",   rdd, d);
        chk(req, "rd_strobe", 32'(rds), 32'(r));
        chk(req, "wr_strobe", 32'(wrs), 32'(w));
        chk(req, "illegal",   32'(ill), 32'(i));
    endtask

    initial begin
        do_reset();
        // R11: outputs clear after reset
        chk("R11", "done",      32'(done), 32'd0);
        chk("R11", "rd_data",   rdd, 32'd0);
        chk("R11", "strobes",   32'({rds, wrs}), 32'd0);
        chk("R11", "illegal",   32'(ill), 32'd0);

        for (int i = 0; i < NV; i++) begin
            issue(TBL[i].instr, TBL[i].rs1);
            expect_out(row_req(i), TBL[i].rd, TBL[i].rs, TBL[i].ws, TBL[i].ill);
            chk("R1", "addr", 32'(addr), 32'(TBL[i].instr[31:20]));
        end

        // R10: idle cycle produces no result
        idle();
        chk("R10", "idle done",    32'(done), 32'd0);
        chk("R10", "idle strobes", 32'({rds, wrs, ill}), 32'd0);

        // R11: scratch cleared by reset
        do_reset();
        issue(enc(12'h340, 5'd0, 3'd2, 5'd1), 32'h0);
        expect_out("R11", 32'h0, 1'b1, 1'b0, 1'b0);

        // R9: counter sequence from a fresh reset
        do_reset();
        issue(enc(12'hC02, 5'd0, 3'd2, 5'd1), 32'h0);
        expect_out("R9", 32'd0, 1'b1, 1'b0, 1'b0);
        issue(enc(12'hC02, 5'd0, 3'd2, 5'd1), 32'h0);
        expect_out("R9", 32'd1, 1'b1, 1'b0, 1'b0);
        idle();
        issue(enc(12'hB02, 5'd0, 3'd2, 5'd1), 32'h0);
        expect_out("R9", 32'd2, 1'b1, 1'b0, 1'b0);        // idle not counted
        issue(enc(12'hB02, 5'd3, 3'd1, 5'd1), 32'd100);
        expect_out("R9", 32'd3, 1'b1, 1'b1, 1'b0);        // old value
        issue(enc(12'hB02, 5'd0, 3'd2, 5'd1), 32'h0);
        expect_out("R9", 32'd100, 1'b1, 1'b0, 1'b0);      // write replaced increment
        issue(enc(12'hC02, 5'd2, 3'd2, 5'd1), 32'h1);
        expect_out("R8", 32'd0, 1'b0, 1'b0, 1'b1);        // alias is read-only
        issue(enc(12'hC02, 5'd0, 3'd2, 5'd1), 32'h0);
        expect_out("R9", 32'd101, 1'b1, 1'b0, 1'b0);      // illegal not counted
        issue(enc(12'hB02, 5'd5, 3'd2, 5'd1), 32'h0);
        expect_out("R5", 32'd102, 1'b1, 1'b1, 1'b0);
        issue(enc(12'hB02, 5'd0, 3'd2, 5'd1), 32'h0);
        expect_out("R9", 32'd102, 1'b1, 1'b0, 1'b0);      // write-back replaced increment

        idle();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule